// File: doc/BRIEF.md
# IR Carrier Waveform Generator

This block produces the square-wave carrier that an infrared transmitter modulates with its symbols. Each period has a high phase and then a low phase. The length of each phase is programmed separately as a number of ticks. A 2-bit select field chooses the tick source: every system clock, or one of three external single-cycle tick pulses (a crystal-derived tick, a 1 µs tick or a 10 µs tick).

Software converts the wanted frequency and duty cycle into the two phase counts. Each count is stored as its length minus one. For example, 38 kHz at 50% on the 1 µs tick is about 13 ticks high and 13 ticks low. The usable range is roughly 25 kHz to 60 kHz at 25% to 75% duty.

The block drives the carrier level. It also drives a one-cycle strobe at the end of every full period, which the downstream symbol engine uses as its timebase. New count values are applied only at a period boundary, so a phase already in progress is never cut short or stretched.

Top module: `irc_carrier_gen`

## Requirements
- R1: `tick_sel_i` picks the tick that advances the phases: 0 counts every system clock, 1 counts `xtal_tick_i`, 2 counts `us1_tick_i`, and 3 counts `us10_tick_i`.
- R2: The high-phase count is `cnt_cfg_i[CW-1:0]`. The low-phase count is `cnt_cfg_i[2*CW-1:CW]`.
- R3: A stored count N keeps its phase for exactly N+1 ticks. With evenly spaced ticks P cycles apart, the phase lasts (N+1)*P system clocks.
- R4: On the first clock edge with `en_i` high after it was low, `carrier_o` goes high. Every period begins with the high phase.
- R5: `period_end_o` is high for exactly one system clock, right after the tick that ends the low phase. `carrier_o` is high in that same cycle, and `period_end_o` is never high while `carrier_o` is low.
- R6: While `en_i` is low, `carrier_o` and `period_end_o` are low. During reset they are also low.
- R7: A change to `cnt_cfg_i` while enabled does not alter the current period. The new counts apply from the next period on.
- R8: Pulses on tick inputs that are not selected have no effect. Without a selected tick, the carrier level does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run the carrier; low stops it and rearms it in the high phase |
| tick_sel_i | input | 2 | Tick source select (0 sys clock, 1 crystal, 2 1 µs, 3 10 µs) |
| xtal_tick_i | input | 1 | Crystal-derived single-cycle tick |
| us1_tick_i | input | 1 | 1 µs single-cycle tick |
| us10_tick_i | input | 1 | 10 µs single-cycle tick |
| cnt_cfg_i | input | 2*CW | Phase counts minus one: high in lower half, low in upper half |
| carrier_o | output | 1 | Carrier level |
| period_end_o | output | 1 | One-cycle strobe at each period end |

## Verification
The carrier is driven from every tick source. Each source pulses at its own rate (every 1, 3, 5 or 7 clocks), so a wrong select shows up as a wrong phase width. The phase counts are asymmetric, which catches swapped halves and missing +1 terms. The cases include minimum counts of zero, a long high phase and the 38 kHz default pair.

A mid-period reprogramming run checks that the old widths finish before the new ones apply. A run with the selected tick gated off while other ticks still pulse shows that unselected ticks cannot move the carrier.

// File: rtl/irc_pkg.sv
package irc_pkg;
  typedef enum logic [1:0] {
    TS_SYS  = 2'd0,
    TS_XTAL = 2'd1,
    TS_US1  = 2'd2,
    TS_US10 = 2'd3
  } tick_src_e;

  typedef enum logic {
    PH_HIGH = 1'b0,
    PH_LOW  = 1'b1
  } phase_e;
endpackage

// File: rtl/irc_tick_sel.sv
module irc_tick_sel
  import irc_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       xtal_tick_i,
  input  logic       us1_tick_i,
  input  logic       us10_tick_i,
  output logic       tick_o
);
  tick_src_e src;
  assign src = tick_src_e'(sel_i);

  always_comb begin
    unique case (src)
      TS_SYS:  tick_o = 1'b1;
      TS_XTAL: tick_o = xtal_tick_i;
      TS_US1:  tick_o = us1_tick_i;
      TS_US10: tick_o = us10_tick_i;
      default: tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/irc_len_shadow.sv
module irc_len_shadow #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] d_i,
  output logic [CW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/irc_phase_seq.sv
module irc_phase_seq
  import irc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic [CW-1:0] hi_len_i,
  input  logic [CW-1:0] lo_len_i,
  output logic          load_o,
  output logic          carrier_o,
  output logic          period_end_o
);
  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic          active_q;
  logic          pend_q;
  logic          adv;
  logic          last;
  logic          wrap;

  assign adv  = en_i & active_q & tick_i;
  assign last = (cnt_q == ((phase_q == PH_HIGH) ? hi_len_i : lo_len_i));
  assign wrap = adv & last & (phase_q == PH_LOW);
  // shadow counts reload while idle and on each period boundary
  assign load_o = ~en_i | wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_HIGH;
      cnt_q    <= '0;
      active_q <= 1'b0;
      pend_q   <= 1'b0;
    end else if (!en_i) begin
      phase_q  <= PH_HIGH;
      cnt_q    <= '0;
      active_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      active_q <= 1'b1;
      pend_q   <= wrap;
      if (adv) begin
        if (last) begin
          cnt_q   <= '0;
          phase_q <= (phase_q == PH_HIGH) ? PH_LOW : PH_HIGH;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign carrier_o    = active_q & (phase_q == PH_HIGH);
  assign period_end_o = pend_q;
endmodule

// File: rtl/irc_carrier_gen.sv
module irc_carrier_gen
  import irc_pkg::*;
#(
  parameter int CW = 16,
  localparam int RW = 2 * CW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [1:0]    tick_sel_i,
  input  logic          xtal_tick_i,
  input  logic          us1_tick_i,
  input  logic          us10_tick_i,
  input  logic [RW-1:0] cnt_cfg_i,
  output logic          carrier_o,
  output logic          period_end_o
);
  logic          tick;
  logic          load;
  logic [CW-1:0] hi_len;
  logic [CW-1:0] lo_len;

  irc_tick_sel u_tick_sel (
    .sel_i       (tick_sel_i),
    .xtal_tick_i (xtal_tick_i),
    .us1_tick_i  (us1_tick_i),
    .us10_tick_i (us10_tick_i),
    .tick_o      (tick)
  );

  irc_len_shadow #(.CW(CW)) u_hi_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .d_i    (cnt_cfg_i[CW-1:0]),
    .q_o    (hi_len)
  );

  irc_len_shadow #(.CW(CW)) u_lo_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .d_i    (cnt_cfg_i[RW-1:CW]),
    .q_o    (lo_len)
  );

  irc_phase_seq #(.CW(CW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .tick_i       (tick),
    .hi_len_i     (hi_len),
    .lo_len_i     (lo_len),
    .load_o       (load),
    .carrier_o    (carrier_o),
    .period_end_o (period_end_o)
  );
endmodule

// File: rtl/irc_carrier_gen_chk.sv
module irc_carrier_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [1:0] tick_sel_i,
  input logic       xtal_tick_i,
  input logic       us1_tick_i,
  input logic       us10_tick_i,
  input logic       carrier_o,
  input logic       period_end_o
);
  logic sel_tick;
  always_comb begin
    case (tick_sel_i)
      2'd0:    sel_tick = 1'b1;
      2'd1:    sel_tick = xtal_tick_i;
      2'd2:    sel_tick = us1_tick_i;
      default: sel_tick = us10_tick_i;
    endcase
  end

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!carrier_o && !period_end_o));

  p_restart_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !$past(en_i)) |=> carrier_o);

  p_strobe_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_o |-> carrier_o);

  p_strobe_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_o |=> !period_end_o);

  p_hold_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && carrier_o && !sel_tick) |=> carrier_o);

  p_hold_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !carrier_o && !sel_tick) |=> !carrier_o);
endmodule

bind irc_carrier_gen irc_carrier_gen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .tick_sel_i   (tick_sel_i),
  .xtal_tick_i  (xtal_tick_i),
  .us1_tick_i   (us1_tick_i),
  .us10_tick_i  (us10_tick_i),
  .carrier_o    (carrier_o),
  .period_end_o (period_end_o)
);

// File: tb/irc_carrier_gen_tb.sv
module irc_carrier_gen_tb;
  localparam int CW = 16;
  localparam int NV = 7;
  // sel, high count, low count, expected high/low widths in clocks
  localparam int V_SEL[NV] = '{0, 0, 1, 2, 3, 2, 0};
  localparam int V_HI [NV] = '{12, 0, 2, 12, 3, 7, 255};
  localparam int V_LO [NV] = '{12, 0, 4, 12, 1, 0, 1};
  localparam int V_EH [NV] = '{13, 1, 9, 65, 28, 40, 256};
  localparam int V_EL [NV] = '{13, 1, 15, 65, 14, 5, 2};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [1:0]    sel = 2'd0;
  logic          xt = 1'b0, t1 = 1'b0, t10 = 1'b0;
  logic          g_xt = 1'b1, g_t1 = 1'b1, g_t10 = 1'b1;
  logic [2*CW-1:0] cfg = '0;
  logic          carrier, pend;
  int            c3 = 0, c5 = 0, c7 = 0;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    c3  <= (c3 == 2) ? 0 : c3 + 1;
    c5  <= (c5 == 4) ? 0 : c5 + 1;
    c7  <= (c7 == 6) ? 0 : c7 + 1;
    xt  <= g_xt  && (c3 == 2);
    t1  <= g_t1  && (c5 == 4);
    t10 <= g_t10 && (c7 == 6);
  end

  irc_carrier_gen #(.CW(CW)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .en_i         (en),
    .tick_sel_i   (sel),
    .xtal_tick_i  (xt),
    .us1_tick_i   (t1),
    .us10_tick_i  (t10),
    .cnt_cfg_i    (cfg),
    .carrier_o    (carrier),
    .period_end_o (pend)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // waits for a strobe, then measures one whole period
  task automatic measure(input int eh, input int el, input string tag);
    int w = 0, h = 0, l = 0, bad = 0;
    while (!pend && w < 5000) begin @(negedge clk); w++; end
    check(pend == 1'b1, {tag, " R5 strobe seen"}, pend, 1);
    while (carrier && h < 5000) begin
      h++; @(negedge clk);
      if (pend) bad++;
    end
    while (!carrier && l < 5000) begin
      l++; @(negedge clk);
      if (pend && !carrier) bad++;
    end
    check(h == eh, {tag, " R3 high width"}, h, eh);
    check(l == el, {tag, " R3 low width"}, l, el);
    check(bad == 0, {tag, " R5 single strobe"}, bad, 0);
    check(pend == 1'b1, {tag, " R5 strobe at low end"}, pend, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(carrier == 1'b0 && pend == 1'b0, "R6 reset state", {carrier, pend}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(carrier == 1'b0, "R6 idle after reset", carrier, 0);

    for (int i = 0; i < NV; i++) begin
      en  = 1'b0;
      sel = V_SEL[i][1:0];
      cfg = {V_LO[i][CW-1:0], V_HI[i][CW-1:0]};
      repeat (2) @(negedge clk);
      en = 1'b1;
      @(negedge clk);
      check(carrier == 1'b1, "R4 restart in high phase", carrier, 1);
      measure(V_EH[i], V_EL[i], $sformatf("R1 R2 vec%0d", i));
    end

    // R6: disable silences output
    en = 1'b0;
    begin
      int seen = 0;
      repeat (20) begin @(negedge clk); if (carrier || pend) seen++; end
      check(seen == 0, "R6 disabled quiet", seen, 0);
    end

    // R7: reprogram mid-period, old widths finish first
    sel = 2'd0; cfg = {16'd3, 16'd3};
    @(negedge clk); en = 1'b1;
    measure(4, 4, "R7 old");
    cfg = {16'd1, 16'd9};
    measure(4, 4, "R7 still old");
    measure(10, 2, "R7 new");

    // R8: selected tick gated off, others still pulse
    en = 1'b0; sel = 2'd1; cfg = {16'd0, 16'd0}; g_xt = 1'b0;
    @(negedge clk); en = 1'b1;
    begin
      int lowc = 0;
      repeat (50) begin @(negedge clk); if (!carrier || pend) lowc++; end
      check(lowc == 0, "R8 no selected tick holds level", lowc, 0);
    end
    g_xt = 1'b1;
    measure(3, 3, "R8 resumes R1");

    // R4: restart mid low phase begins high again
    en = 1'b0; sel = 2'd0; cfg = {16'd20, 16'd0};
    @(negedge clk); en = 1'b1;
    repeat (5) @(negedge clk);
    check(carrier == 1'b0, "R4 in low phase", carrier, 0);
    en = 1'b0; @(negedge clk); en = 1'b1; @(negedge clk);
    check(carrier == 1'b1, "R4 restart from low", carrier, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule